// File: doc/BRIEF.md
# Hashed Layer-2 Address Table Lookup

This block holds a layer-2 forwarding table and answers lookups against it. The main store is a hash-indexed SRAM split into buckets of four ways. A small fully searched CAM catches entries that do not fit in their bucket. A lookup presents a 60-bit key, made of a 48-bit MAC address and a 12-bit VLAN/FID. The block folds the key into a 12-bit bucket hash with one of two XOR-fold algorithms. It then compares the key against the four ways of that bucket and against every CAM entry. One cycle later it returns a hit flag, the source of the hit, the hash and the matching 96-bit entry. The common unicast fields of that entry are also returned already decoded.

Software fills and inspects both tables through a small host window. The window has a command word, three 32-bit data words and a control word. Setting the execute bit of the command runs one read or write of a single entry in the table that the command names. The execute bit then clears itself. Learning, aging and the packet datapath sit outside this block.

Top module: `l2_table_lookup`

## Requirements
- R1: A key carries the MAC address in bits 59:12 and the VLAN/FID in bits 11:0. A stored entry is three words: word0 holds MAC bits 47:16, word1 bits 31:16 hold MAC bits 15:0, word2 bits 15:4 hold the VLAN/FID, and word2 bit 31 marks the entry valid. An entry matches only when it is valid and its MAC and VLAN/FID both equal the key's.
- R2: In hash mode 1 the hash is {hi, lo}. Take the key zero-extended to 64 bits. The 6-bit value hi is the XOR of the 6-bit slices starting at bits 0+60, 54, 36, 30, 12 and 6. The 6-bit value lo is the XOR of the slices starting at bits 48, 42, 24, 18 and 0.
- R3: In hash mode 0 the 12-bit hash is the XOR of six terms: the key shifted right by 60, the 12-bit value {key[53:48], key[59:54]}, and the 12-bit slices starting at bits 36, 24, 12 and 0.
- R4: Host word 4, bit 0, selects the hash mode. It resets to 0 (mode 0) and reads back.
- R5: An SRAM entry index is {hash, way}, with the way as the 2-bit low part. The table keeps the low SRAM_ADDR_W bits of that index. A lookup checks the four ways of its bucket, and the lowest matching way wins.
- R6: The command word (host word 0) is laid out as follows. Bit 17 is execute. Bit 16 selects write (1) or read (0). Bits 15:14 give the table: 00 for the SRAM, 01 for the CAM. Bits 13:0 give the index, and the CAM uses only the low 6 bits of it. A write copies data words 1..3 (entry words 0..2) into the indexed entry. A read loads the indexed entry into those data words.
- R7: Execute reads back as 1 for exactly one cycle after the command is written, then clears. While execute is set, every host write is ignored.
- R8: A command with table type 10 or 11 changes neither table and leaves the data words unchanged.
- R9: A lookup request is answered in the next cycle. rsp_valid pulses for one cycle, and rsp_hash carries the hash of the key.
- R10: When both the SRAM bucket and the CAM hold a match, the SRAM entry is returned and rsp_from_cam is 0. A hit found only in the CAM sets rsp_from_cam to 1. Among CAM entries, the lowest index wins.
- R11: On a miss, rsp_hit is 0 and rsp_entry is all zeros.
- R12: After reset, all host words read 0, execute is clear, rsp_valid is 0 and both tables are empty.
- R13: Fields decoded from word2 of the returned entry: port is bits 29:24, age is bits 22:21, static is bit 18, block-DA is bit 19 and block-SA is bit 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host word: 0 command, 1..3 data, 4 control |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| lk_req | input | 1 | Lookup request |
| lk_key | input | 60 | Lookup key {MAC, VLAN/FID} |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | A matching entry was found |
| rsp_from_cam | output | 1 | The match came from the CAM |
| rsp_hash | output | 12 | Bucket hash of the key |
| rsp_entry | output | 96 | Matching entry {word2, word1, word0} |
| rsp_port | output | 6 | Port field of the entry |
| rsp_age | output | 2 | Age field of the entry |
| rsp_static | output | 1 | Static flag of the entry |
| rsp_block_sa | output | 1 | Block-source flag of the entry |
| rsp_block_da | output | 1 | Block-destination flag of the entry |

## Verification
The assertions check several timing rules on every cycle. A lookup answer appears exactly one cycle after each request and at no other time. An execute clears one cycle after it is set. An SRAM match always wins over a CAM match. A miss always returns a zeroed entry. Other behaviour only directed scenarios can show, because each needs an expected value worked out from the key:
- the two hash folds for chosen keys;
- placing an entry at {hash, way} and finding it again;
- way ordering inside a bucket and CAM fallback;
- invalid entries that do not match;
- unused table types that have no effect;
- commands written during a busy cycle that are dropped.

// File: rtl/l2lk_pkg.sv
// Shared types and helpers for the layer-2 table lookup.
// Assumes a 60-bit key {MAC[47:0], VID[11:0]} and three-word entries.
package l2lk_pkg;

    localparam int KEY_W   = 60;
    localparam int HASH_W  = 12;
    localparam int WAYS    = 4;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int IDX_W   = HASH_W + WAY_W;

    typedef enum logic [1:0] {
        TBL_SRAM = 2'b00,
        TBL_CAM  = 2'b01,
        TBL_RSV2 = 2'b10,
        TBL_RSV3 = 2'b11
    } tbl_sel_e;

    typedef struct packed {
        logic [31:0] w2;   // valid[31], port[29:24], age[22:21], flags[20:18], vid[15:4]
        logic [31:0] w1;   // mac[15:0] in [31:16]
        logic [31:0] w0;   // mac[47:16]
    } l2_entry_t;

    // True when the entry is valid and holds exactly this key.
    function automatic logic entry_hit(input l2_entry_t e, input logic [KEY_W-1:0] key);
        return e.w2[31] && (e.w0 == key[59:28]) && (e.w1[31:16] == key[27:12])
               && (e.w2[15:4] == key[11:0]);
    endfunction

endpackage

// File: rtl/l2lk_hash.sv
// Bucket hash of a 60-bit key: two selectable XOR folds to 12 bits.
// Purely combinational; mode is a level from the control word.
module l2lk_hash
    import l2lk_pkg::*;
(
    input  logic [KEY_W-1:0]  key,
    input  logic              mode,
    output logic [HASH_W-1:0] hash
);
    logic [63:0] k64;
    logic [5:0]  hi, lo;

    assign k64 = {{(64-KEY_W){1'b0}}, key};

    // Fold the key under the selected algorithm.
    always_comb begin
        hi = 6'(k64 >> 60) ^ 6'(k64 >> 54) ^ 6'(k64 >> 36)
           ^ 6'(k64 >> 30) ^ 6'(k64 >> 12) ^ 6'(k64 >> 6);
        lo = 6'(k64 >> 48) ^ 6'(k64 >> 42) ^ 6'(k64 >> 24)
           ^ 6'(k64 >> 18) ^ 6'(k64);
        if (mode)
            hash = {hi, lo};
        else
            hash = 12'(k64 >> 60) ^ {k64[53:48], k64[59:54]} ^ 12'(k64 >> 36)
                 ^ 12'(k64 >> 24) ^ 12'(k64 >> 12) ^ 12'(k64);
    end
endmodule

// File: rtl/l2lk_table.sv
// Entry store with one host write/read port and a one-cycle key search.
// FULL_SEARCH=0: the four ways of the hashed bucket are compared.
// FULL_SEARCH=1: every entry is compared (CAM); hash is unused.
// Lowest candidate index wins among several matches.
module l2lk_table
    import l2lk_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter bit FULL_SEARCH = 1'b0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  l2_entry_t         wentry,
    output l2_entry_t         rentry,
    input  logic [KEY_W-1:0]  key,
    input  logic [HASH_W-1:0] hash,
    output logic              hit,
    output l2_entry_t         hit_entry
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NCAND = FULL_SEARCH ? DEPTH : WAYS;

    l2_entry_t mem   [DEPTH];
    l2_entry_t cand  [NCAND];

    // Storage: cleared on reset, written by host commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wentry;
        end
    end

    assign rentry = mem[addr];

    generate
        if (FULL_SEARCH) begin : g_full
            logic unused_hash;
            assign unused_hash = ^hash;
            for (genvar i = 0; i < NCAND; i++) begin : g_c
                assign cand[i] = mem[i];
            end
        end else begin : g_bucket
            for (genvar w = 0; w < NCAND; w++) begin : g_c
                assign cand[w] = mem[ADDR_W'({hash, WAY_W'(w)})];
            end
        end
    endgenerate

    // Priority search: scan downwards so the lowest match remains.
    always_comb begin
        hit       = 1'b0;
        hit_entry = '0;
        for (int i = NCAND - 1; i >= 0; i--) begin
            if (entry_hit(cand[i], key)) begin
                hit       = 1'b1;
                hit_entry = cand[i];
            end
        end
    end
endmodule

// File: rtl/l2lk_host.sv
// Host window: command word, three data words, control word.
// An execute runs in the cycle after it is written, then self-clears;
// host writes arriving while it is pending are dropped.
module l2lk_host
    import l2lk_pkg::*;
#(
    parameter int SRAM_AW = 8,
    parameter int CAM_AW  = 6
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [2:0]         host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               hash_mode,
    output logic               sram_we,
    output logic               cam_we,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [CAM_AW-1:0]  cam_addr,
    output l2_entry_t          wr_entry,
    input  l2_entry_t          sram_rentry,
    input  l2_entry_t          cam_rentry
);
    logic      busy_q;
    logic [16:0] cmd_q;
    logic      mode_q;
    l2_entry_t data_q;
    tbl_sel_e  tbl;
    logic      is_wr;

    assign tbl   = tbl_sel_e'(cmd_q[15:14]);
    assign is_wr = cmd_q[16];

    // Command, data and control registers plus the one-cycle execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cmd_q  <= '0;
            mode_q <= 1'b0;
            data_q <= '0;
        end else if (busy_q) begin
            busy_q <= 1'b0;
            if (!is_wr && tbl == TBL_SRAM) data_q <= sram_rentry;
            else if (!is_wr && tbl == TBL_CAM) data_q <= cam_rentry;
        end else if (host_we) begin
            case (host_addr)
                3'd0: begin cmd_q <= host_wdata[16:0]; busy_q <= host_wdata[17]; end
                3'd1: data_q.w0 <= host_wdata;
                3'd2: data_q.w1 <= host_wdata;
                3'd3: data_q.w2 <= host_wdata;
                3'd4: mode_q <= host_wdata[0];
                default: ;
            endcase
        end
    end

    // Read mux for the host window.
    always_comb begin
        case (host_addr)
            3'd0:    host_rdata = {14'b0, busy_q, cmd_q};
            3'd1:    host_rdata = data_q.w0;
            3'd2:    host_rdata = data_q.w1;
            3'd3:    host_rdata = data_q.w2;
            3'd4:    host_rdata = {31'b0, mode_q};
            default: host_rdata = '0;
        endcase
    end

    assign hash_mode = mode_q;
    assign sram_we   = busy_q && is_wr && tbl == TBL_SRAM;
    assign cam_we    = busy_q && is_wr && tbl == TBL_CAM;
    assign sram_addr = SRAM_AW'(cmd_q[13:0]);
    assign cam_addr  = CAM_AW'(cmd_q[13:0]);
    assign wr_entry  = data_q;

    AST_EXEC_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !busy_q); // R7
    AST_EXEC_START: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 3'd0 && host_wdata[17] && !busy_q) |=> busy_q); // R6
endmodule

// File: rtl/l2_table_lookup.sv
// Top of the layer-2 table lookup: hash, bucketed SRAM, overflow CAM,
// host window and a registered lookup answer (one cycle after request).
// SRAM matches take priority over CAM matches.
module l2_table_lookup
    import l2lk_pkg::*;
#(
    parameter int SRAM_ADDR_W = 8,
    parameter int CAM_DEPTH   = 64
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              lk_req,
    input  logic [KEY_W-1:0]  lk_key,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_from_cam,
    output logic [HASH_W-1:0] rsp_hash,
    output logic [95:0]       rsp_entry,
    output logic [5:0]        rsp_port,
    output logic [1:0]        rsp_age,
    output logic              rsp_static,
    output logic              rsp_block_sa,
    output logic              rsp_block_da
);
    localparam int CAM_AW = $clog2(CAM_DEPTH);

    logic              hash_mode, sram_we, cam_we, sram_hit, cam_hit;
    logic [SRAM_ADDR_W-1:0] sram_addr;
    logic [CAM_AW-1:0] cam_addr;
    logic [HASH_W-1:0] hash;
    l2_entry_t         wr_entry, sram_rentry, cam_rentry, sram_e, cam_e, rsp_q;

    l2lk_host #(.SRAM_AW(SRAM_ADDR_W), .CAM_AW(CAM_AW)) u_host (
        .clk, .rst_n, .host_we, .host_addr, .host_wdata, .host_rdata,
        .hash_mode, .sram_we, .cam_we, .sram_addr, .cam_addr, .wr_entry,
        .sram_rentry, .cam_rentry
    );

    l2lk_hash u_hash (.key(lk_key), .mode(hash_mode), .hash(hash));

    l2lk_table #(.ADDR_W(SRAM_ADDR_W), .FULL_SEARCH(1'b0)) u_sram (
        .clk, .rst_n, .we(sram_we), .addr(sram_addr), .wentry(wr_entry),
        .rentry(sram_rentry), .key(lk_key), .hash(hash),
        .hit(sram_hit), .hit_entry(sram_e)
    );

    l2lk_table #(.ADDR_W(CAM_AW), .FULL_SEARCH(1'b1)) u_cam (
        .clk, .rst_n, .we(cam_we), .addr(cam_addr), .wentry(wr_entry),
        .rentry(cam_rentry), .key(lk_key), .hash(hash),
        .hit(cam_hit), .hit_entry(cam_e)
    );

    // Register the answer, SRAM first, CAM second, zeros on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_from_cam <= 1'b0;
            rsp_hash     <= '0;
            rsp_q        <= '0;
        end else begin
            rsp_valid <= lk_req;
            if (lk_req) begin
                rsp_hash     <= hash;
                rsp_hit      <= sram_hit || cam_hit;
                rsp_from_cam <= !sram_hit && cam_hit;
                rsp_q        <= sram_hit ? sram_e : (cam_hit ? cam_e : '0);
            end
        end
    end

    assign rsp_entry    = rsp_q;
    assign rsp_port     = rsp_q.w2[29:24];
    assign rsp_age      = rsp_q.w2[22:21];
    assign rsp_static   = rsp_q.w2[18];
    assign rsp_block_da = rsp_q.w2[19];
    assign rsp_block_sa = rsp_q.w2[20];

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid); // R9
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid); // R9
    AST_SRAM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && sram_hit) |=> (rsp_hit && !rsp_from_cam)); // R10
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_entry == '0)); // R11
endmodule

// File: tb/test_l2_table_lookup.sv
module test_l2_table_lookup;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        lk_req = 1'b0;
    logic [59:0] lk_key = '0;
    logic        rsp_valid, rsp_hit, rsp_from_cam, rsp_static, rsp_block_sa, rsp_block_da;
    logic [11:0] rsp_hash;
    logic [95:0] rsp_entry;
    logic [5:0]  rsp_port;
    logic [1:0]  rsp_age;

    int n_checks = 0;
    int n_fail   = 0;

    l2_table_lookup i_l2_table_lookup (
        .clk, .rst_n, .host_we, .host_addr, .host_wdata, .host_rdata,
        .lk_req, .lk_key, .rsp_valid, .rsp_hit, .rsp_from_cam, .rsp_hash,
        .rsp_entry, .rsp_port, .rsp_age, .rsp_static, .rsp_block_sa, .rsp_block_da
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    localparam logic [59:0] K1 = {48'hABCD_EF12_3456, 12'h00A};
    localparam logic [59:0] K2 = {48'h0011_2233_4455, 12'h7FE};
    localparam logic [59:0] K3 = {48'hFEDC_BA98_7654, 12'h321};
    localparam logic [59:0] K4 = {48'h5A5A_0F0F_C3C3, 12'hABC};

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference hash written from the requirements
    function automatic logic [11:0] ref_hash(input logic [59:0] k, input logic mode);
        logic [63:0] x;
        logic [5:0]  a, b;
        int hp[6] = '{60, 54, 36, 30, 12, 6};
        int lp[5] = '{48, 42, 24, 18, 0};
        x = {4'b0, k};
        if (mode) begin
            a = '0; b = '0;
            foreach (hp[i]) a = a ^ x[hp[i] +: 6];
            foreach (lp[i]) b = b ^ x[lp[i] +: 6];
            return {a, b};
        end
        return {8'b0, x[63:60]} ^ {x[53:48], x[59:54]} ^ x[47:36] ^ x[35:24]
             ^ x[23:12] ^ x[11:0];
    endfunction

    function automatic logic [95:0] mk_entry(input logic [59:0] k, input logic v,
            input logic [5:0] port, input logic [1:0] age, input logic [2:0] flg);
        logic [31:0] w0, w1, w2;
        w0 = k[59:28];
        w1 = {k[27:12], 16'h0};
        w2 = {v, 1'b0, port, 1'b0, age, flg, 2'b00, k[11:0], 4'h0};
        return {w2, w1, w0};
    endfunction

    task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic load_data(input logic [95:0] e);
        hwrite(3'd1, e[31:0]);
        hwrite(3'd2, e[63:32]);
        hwrite(3'd3, e[95:64]);
    endtask

    function automatic logic [31:0] cmd(input logic wr, input logic [1:0] t, input logic [13:0] idx);
        return {14'b0, 1'b1, wr, t, idx};
    endfunction

    task automatic exec(input logic wr, input logic [1:0] t, input logic [13:0] idx);
        hwrite(3'd0, cmd(wr, t, idx));
        @(negedge clk);
    endtask

    task automatic lookup(input logic [59:0] k);
        @(negedge clk);
        lk_req = 1'b1; lk_key = k;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    function automatic logic [13:0] sidx(input logic [59:0] k, input logic [1:0] way);
        return {ref_hash(k, 1'b1), way};
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 5; a++) begin
            hread(3'(a), d);
            check("R12 host word after reset", 96'(d), 96'h0);
        end
        check("R12 rsp_valid after reset", 96'(rsp_valid), 96'h0);
        lookup(K1);
        check("R12 empty tables miss", 96'(rsp_hit), 96'h0);
    endtask

    task automatic t_hash_mode0;
        logic [59:0] keys[3] = '{K1, K2, 60'hFFF_FFFF_FFFF_FFFF};
        foreach (keys[i]) begin
            lookup(keys[i]);
            check("R9 rsp_valid one cycle after request", 96'(rsp_valid), 96'h1);
            check("R3 mode 0 hash", 96'(rsp_hash), 96'(ref_hash(keys[i], 1'b0)));
        end
        @(negedge clk);
        check("R9 rsp_valid is a single pulse", 96'(rsp_valid), 96'h0);
    endtask

    task automatic t_hash_mode1;
        logic [31:0] d;
        logic [59:0] keys[3] = '{K1, K3, 60'hFFF_FFFF_FFFF_FFFF};
        hwrite(3'd4, 32'h1);
        hread(3'd4, d);
        check("R4 control word reads back", 96'(d), 96'h1);
        foreach (keys[i]) begin
            lookup(keys[i]);
            check("R2 mode 1 hash", 96'(rsp_hash), 96'(ref_hash(keys[i], 1'b1)));
        end
    endtask

    task automatic t_sram_rw;
        logic [31:0] d;
        logic [95:0] e;
        e = mk_entry(K1, 1'b1, 6'd37, 2'd2, 3'b101);
        load_data(e);
        hwrite(3'd0, cmd(1'b1, 2'b00, sidx(K1, 2'd2)));
        hread(3'd0, d);
        check("R7 execute visible for one cycle", 96'(d[17]), 96'h1);
        @(negedge clk);
        hread(3'd0, d);
        check("R7 execute self-clears", 96'(d[17]), 96'h0);
        load_data('0);
        exec(1'b0, 2'b00, sidx(K1, 2'd2));
        hread(3'd1, d); check("R6 read back word0", 96'(d), 96'(e[31:0]));
        hread(3'd2, d); check("R6 read back word1", 96'(d), 96'(e[63:32]));
        hread(3'd3, d); check("R6 read back word2", 96'(d), 96'(e[95:64]));
    endtask

    task automatic t_lookup_sram;
        lookup(K1);
        check("R5 SRAM bucket hit", 96'(rsp_hit), 96'h1);
        check("R5 hit from SRAM", 96'(rsp_from_cam), 96'h0);
        check("R1 returned entry", rsp_entry, mk_entry(K1, 1'b1, 6'd37, 2'd2, 3'b101));
        check("R13 port", 96'(rsp_port), 96'd37);
        check("R13 age", 96'(rsp_age), 96'd2);
        check("R13 flags sa/da/static", 96'({rsp_block_sa, rsp_block_da, rsp_static}), 96'b101);
    endtask

    task automatic t_cam;
        logic [95:0] e;
        e = mk_entry(K2, 1'b1, 6'd5, 2'd1, 3'b010);
        load_data(e);
        exec(1'b1, 2'b01, 14'h3C25);
        lookup(K2);
        check("R6 CAM hit", 96'(rsp_hit), 96'h1);
        check("R10 CAM-only hit flagged", 96'(rsp_from_cam), 96'h1);
        check("R6 CAM entry", rsp_entry, e);
        load_data('0);
        exec(1'b0, 2'b01, 14'h0025);
        hread(3'd2, e[63:32]);
        check("R6 CAM index uses low 6 bits", 96'(e[63:32]), 96'({K2[27:12], 16'h0}));
    endtask

    task automatic t_priority;
        logic [95:0] e;
        e = mk_entry(K1, 1'b1, 6'd9, 2'd0, 3'b000);
        load_data(e);
        exec(1'b1, 2'b01, 14'd0);
        lookup(K1);
        check("R10 SRAM beats CAM", 96'(rsp_from_cam), 96'h0);
        check("R10 SRAM entry returned", 96'(rsp_port), 96'd37);
    endtask

    task automatic t_miss;
        lookup({K1[59:12], 12'h00B});
        check("R1 VID mismatch misses", 96'(rsp_hit), 96'h0);
        check("R11 miss entry zero", rsp_entry, 96'h0);
        load_data(mk_entry(K3, 1'b0, 6'd1, 2'd0, 3'b000));
        exec(1'b1, 2'b00, sidx(K3, 2'd0));
        lookup(K3);
        check("R1 invalid entry does not match", 96'(rsp_hit), 96'h0);
    endtask

    task automatic t_way_order;
        load_data(mk_entry(K3, 1'b1, 6'd60, 2'd3, 3'b000));
        exec(1'b1, 2'b00, sidx(K3, 2'd3));
        load_data(mk_entry(K3, 1'b1, 6'd11, 2'd1, 3'b000));
        exec(1'b1, 2'b00, sidx(K3, 2'd1));
        lookup(K3);
        check("R5 lowest matching way wins", 96'(rsp_port), 96'd11);
    endtask

    task automatic t_bad_type;
        logic [31:0] d;
        load_data(mk_entry(K1, 1'b1, 6'd63, 2'd3, 3'b111));
        exec(1'b1, 2'b11, sidx(K1, 2'd2));
        exec(1'b1, 2'b10, 14'd0);
        lookup(K1);
        check("R8 type 11 write leaves SRAM", 96'(rsp_port), 96'd37);
        lookup(K2);
        check("R8 type 10 write leaves CAM", 96'(rsp_port), 96'd5);
        exec(1'b0, 2'b10, sidx(K1, 2'd2));
        hread(3'd3, d);
        check("R8 type 10 read leaves data", 96'(d[29:24]), 96'd63);
    endtask

    task automatic t_busy_ignore;
        load_data(mk_entry(K4, 1'b1, 6'd2, 2'd0, 3'b000));
        hwrite(3'd0, cmd(1'b0, 2'b10, 14'd0));
        host_addr = 3'd0; host_wdata = cmd(1'b1, 2'b00, sidx(K4, 2'd0)); host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        @(negedge clk);
        lookup(K4);
        check("R7 command during execute dropped", 96'(rsp_hit), 96'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hash_mode0();
        t_hash_mode1();
        t_sram_rw();
        t_lookup_sram();
        t_cam();
        t_priority();
        t_miss();
        t_way_order();
        t_bad_type();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule